// File: doc/BRIEF.md
# Voice Processor Command Receiver

This block is a two-wire serial bus slave that accepts host commands for a voice-enhancement processor and holds its control state. A host writes one or two bytes after the device address: a command byte and, for some commands, a data byte. The commands switch the processing mode, load equaliser presets, set per-band and per-filter gains, set the processing level, and set the noise threshold. A query command chooses which byte the next read transfer returns: a status byte or one band's tone level.

SCL and SDA are sampled by a much faster system clock. Each line passes through a two-flop synchroniser and then a three-sample majority vote, and only then is it checked for edges. SDA is open-drain: the block only ever pulls it low, through `sda_oe`. The control fields appear as parallel outputs for the audio datapath.

Top module: `voice_ctl_i2c_regs`

## Requirements
- R1: After reset the outputs are as follows. `dsp_off`=1, `eq_mode`=0, `level`=01, the band gains (band1..band4) are 0x10/0x0C/0x0C/0x0D, every filter gain is 0xC, `noise_thr`=0x1F, `sda_oe`=0, and a read returns the status byte.
- R2: The device answers the 7-bit address {100000, `addr_sel`} and acknowledges the address byte and the next two bytes. It does not acknowledge any other address, and a transfer to another address changes no register.
- R3: Command 0x01 sets `dsp_off`=1 and keeps `eq_mode`. Command 0x02 sets `dsp_off`=0 and `eq_mode`=0. Command 0x03 sets `dsp_off`=0 and `eq_mode`=1.
- R4: Commands 0x04..0x08 load the band gains (band1/2/3/4, code = 12 + dB) as follows: 0x04 gives 0/0/0/0 dB, 0x05 gives +3/-1/-1/+1, 0x06 gives +3/0/0/+3, 0x07 gives +5/0/0/0, and 0x08 gives +5/0/0/+1.
- R5: Command 0x09 with data 0x00, 0x01 or 0x02 sets `level` to that code. Any other data byte leaves `level` unchanged.
- R6: Command 0x0A with data {band[2:0], gain[4:0]} sets the gain of band band+1 when band ≤ 3 and gain ≤ 0x18. In every other case the band gains are unchanged. Band k occupies `band_gain[5k+4:5k]`, with k=0 for band1.
- R7: Command 0x0B with data {idx[3:0], gain[3:0]} sets filter gain idx when idx ≤ 9 and gain ≤ 0xC. In every other case the filter gains are unchanged. Filter i occupies `filt_gain[4i+3:4i]`.
- R8: Command 0x0D loads its data byte into `noise_thr`.
- R9: Command 0x0E with data 0x01 makes reads return the status byte {0000, level[1:0], eq_mode, dsp_off}. Data 0x02..0x05 makes reads return {000, gain of band 1..4}. Any other data byte keeps the previous selection. The read byte is sent MSB first.
- R10: An unknown command byte is acknowledged and changes no register.
- R11: A pulse on SCL or SDA that lasts one system clock is ignored.
- R12: `sda_oe` changes only while the filtered SCL is low, and it is 0 outside acknowledge slots and read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Low bit of the device address |
| sda_oe | output | 1 | 1 pulls SDA low |
| dsp_off | output | 1 | 1 = processing bypassed |
| eq_mode | output | 1 | 0 = VIP mode, 1 = equaliser mode |
| level | output | 2 | Processing level: 00 = 100%, 01 = 80%, 10 = 60% |
| band_gain | output | 20 | Four 5-bit band gain codes |
| filt_gain | output | 40 | Ten 4-bit filter gain codes |
| noise_thr | output | 8 | Noise threshold |

## Verification
The hardest situation to reach is a one-clock glitch on the bus lines. Two kinds matter: a spurious SCL pulse in the middle of a byte, which would insert an extra bit, and an SDA dip while SCL is high, which would look like a start condition. The bench ORs a single-clock pulse onto SCL during a low phase. It also pulls SDA low for one clock during every high data bit. It then checks that the command still lands with the intended value. Out-of-range data bytes and query selectors are confirmed as ignored by reading the affected field back over the bus.

// File: rtl/voice_ctl_i2c_regs.sv
module voice_ctl_i2c_regs #(
  parameter logic [5:0] ADDR_HI = 6'b100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        addr_sel,
  output logic        sda_oe,
  output logic        dsp_off,
  output logic        eq_mode,
  output logic [1:0]  level,
  output logic [19:0] band_gain,
  output logic [39:0] filt_gain,
  output logic [7:0]  noise_thr
);

  localparam int NBAND = 4;
  localparam int BGW   = 5;
  localparam int NFILT = 10;
  localparam int FGW   = 4;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_SKIP} st_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

  function automatic logic [19:0] preset(input logic [2:0] n);
    case (n)
      3'd1:    return {5'd13, 5'd11, 5'd11, 5'd15};
      3'd2:    return {5'd15, 5'd12, 5'd12, 5'd15};
      3'd3:    return {5'd12, 5'd12, 5'd12, 5'd17};
      3'd4:    return {5'd13, 5'd12, 5'd12, 5'd17};
      default: return {5'd12, 5'd12, 5'd12, 5'd12};
    endcase
  endfunction

  logic [1:0] scl_s, sda_s;
  logic [2:0] scl_h, sda_h;
  logic       scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[1:0], scl_s[1]};
      sda_h <= {sda_h[1:0], sda_s[1]};
      scl_f <= maj3(scl_h);
      sda_f <= maj3(sda_h);
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  st_t        st;
  logic [7:0] sh, cmd, tx;
  logic [3:0] bcnt;
  logic [1:0] bidx;
  logic       rd;
  logic [2:0] qsel;
  logic [BGW-1:0] bg [NBAND];
  logic [FGW-1:0] fg [NFILT];

  wire byte_done = (st == S_RX) && scl_fall && (bcnt == 4'd8) && !start_c && !stop_c;
  wire wr_cmd    = byte_done && (bidx == 2'd1);
  wire wr_dat    = byte_done && (bidx == 2'd2);
  wire [19:0] pre_v = preset(sh[2:0] - 3'd4);

  always_comb begin
    case (qsel)
      3'd2:    tx = {3'b000, bg[0]};
      3'd3:    tx = {3'b000, bg[1]};
      3'd4:    tx = {3'b000, bg[2]};
      3'd5:    tx = {3'b000, bg[3]};
      default: tx = {4'b0000, level, eq_mode, dsp_off};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; cmd <= '0; bcnt <= '0; bidx <= '0;
      rd <= 1'b0; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= S_RX; bcnt <= '0; bidx <= '0; rd <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_f};
            bcnt <= bcnt + 4'd1;
          end else if (byte_done) begin
            bcnt <= '0;
            if (bidx == 2'd0) begin
              if (sh[7:1] == {ADDR_HI, addr_sel}) begin
                rd <= sh[0]; sda_oe <= 1'b1; st <= S_ACK;
              end else begin
                st <= S_SKIP;
              end
            end else if (bidx == 2'd3) begin
              st <= S_SKIP;
            end else begin
              sda_oe <= 1'b1; st <= S_ACK;
              if (bidx == 2'd1) cmd <= sh;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bidx <= bidx + 2'd1;
            if (rd) begin
              st <= S_TX; sh <= tx; sda_oe <= ~tx[7]; bcnt <= 4'd1;
            end else begin
              st <= S_RX; sda_oe <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bcnt == 4'd8) begin
              sda_oe <= 1'b0; st <= S_SKIP;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[6:0], 1'b0};
              bcnt   <= bcnt + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_off <= 1'b1; eq_mode <= 1'b0; level <= 2'b01;
      noise_thr <= 8'h1F; qsel <= 3'd1;
      bg[0] <= 5'd16; bg[1] <= 5'd12; bg[2] <= 5'd12; bg[3] <= 5'd13;
      for (int i = 0; i < NFILT; i++) fg[i] <= 4'hC;
    end else if (wr_cmd) begin
      case (sh)
        8'h01: dsp_off <= 1'b1;
        8'h02: begin dsp_off <= 1'b0; eq_mode <= 1'b0; end
        8'h03: begin dsp_off <= 1'b0; eq_mode <= 1'b1; end
        8'h04, 8'h05, 8'h06, 8'h07, 8'h08:
          for (int k = 0; k < NBAND; k++) bg[k] <= pre_v[k*BGW +: BGW];
        default: ;
      endcase
    end else if (wr_dat) begin
      case (cmd)
        8'h09: if (sh <= 8'd2) level <= sh[1:0];
        8'h0A: if (sh[7:5] <= 3'd3 && sh[4:0] <= 5'd24) bg[sh[6:5]] <= sh[4:0];
        8'h0B: if (sh[7:4] <= 4'd9 && sh[3:0] <= 4'd12) fg[sh[7:4]] <= sh[3:0];
        8'h0D: noise_thr <= sh;
        8'h0E: if (sh >= 8'd1 && sh <= 8'd5) qsel <= sh[2:0];
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NBAND; k++) begin : g_band
    assign band_gain[k*BGW +: BGW] = bg[k];
  end
  for (genvar i = 0; i < NFILT; i++) begin : g_filt
    assign filt_gain[i*FGW +: FGW] = fg[i];
  end

endmodule

module voice_ctl_i2c_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_f,
  input logic        sda_oe,
  input logic        dsp_off,
  input logic        eq_mode,
  input logic [1:0]  level,
  input logic [19:0] band_gain,
  input logic [39:0] filt_gain
);
  logic bands_ok, filts_ok;
  always_comb begin
    bands_ok = 1'b1;
    for (int k = 0; k < 4; k++) if (band_gain[k*5 +: 5] > 5'd24) bands_ok = 1'b0;
    filts_ok = 1'b1;
    for (int i = 0; i < 10; i++) if (filt_gain[i*4 +: 4] > 4'd12) filts_ok = 1'b0;
  end

  assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);
  assert_level_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'b11);
  assert_band_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bands_ok);
  assert_filt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    filts_ok);
  assert_eq_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eq_mode) |-> !dsp_off);
  assert_vip_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eq_mode) |-> !dsp_off);
endmodule

bind voice_ctl_i2c_regs voice_ctl_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe), .dsp_off(dsp_off),
  .eq_mode(eq_mode), .level(level), .band_gain(band_gain), .filt_gain(filt_gain)
);

// File: tb/voice_ctl_i2c_regs_tb.sv
`timescale 1ns/1ps
module voice_ctl_i2c_regs_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
  logic addr_sel = 1'b0;
  logic sda_oe, dsp_off, eq_mode;
  logic [1:0] level;
  logic [19:0] band_gain;
  logic [39:0] filt_gain;
  logic [7:0] noise_thr;
  wire scl_i = m_scl | g_scl;
  wire sda_i = m_sda & ~sda_oe & ~g_sda;

  int checks = 0, fails = 0, gmode = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  voice_ctl_i2c_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .dsp_off(dsp_off), .eq_mode(eq_mode), .level(level),
    .band_gain(band_gain), .filt_gain(filt_gain), .noise_thr(noise_thr)
  );

  // {cmd, data, has_data, query, expected read byte}
  localparam logic [39:0] VEC [17] = '{
    {8'h02, 8'h00, 8'h00, 8'h01, 8'h04},  // R3 VIP on
    {8'h03, 8'h00, 8'h00, 8'h01, 8'h06},  // R3 EQ on
    {8'h01, 8'h00, 8'h00, 8'h01, 8'h07},  // R3 bypass keeps mode
    {8'h09, 8'h00, 8'h01, 8'h01, 8'h03},  // R5 100%
    {8'h09, 8'h02, 8'h01, 8'h01, 8'h0B},  // R5 60%
    {8'h09, 8'h03, 8'h01, 8'h01, 8'h0B},  // R5 bad code ignored
    {8'h05, 8'h00, 8'h00, 8'h02, 8'h0F},  // R4 preset1 band1
    {8'h7F, 8'h00, 8'h00, 8'h03, 8'h0B},  // R10 unknown, band2 kept
    {8'h06, 8'h00, 8'h00, 8'h05, 8'h0F},  // R4 preset2 band4
    {8'h0A, 8'h58, 8'h01, 8'h04, 8'h18},  // R6 band3 +12
    {8'h0A, 8'h59, 8'h01, 8'h04, 8'h18},  // R6 gain 25 ignored
    {8'h0A, 8'h81, 8'h01, 8'h02, 8'h0F},  // R6 band code 100 ignored
    {8'h04, 8'h00, 8'h00, 8'h02, 8'h0C},  // R4 flat
    {8'h08, 8'h00, 8'h00, 8'h05, 8'h0D},  // R4 preset4 band4
    {8'h07, 8'h00, 8'h00, 8'h02, 8'h11},  // R4 preset3 band1
    {8'h0A, 8'h00, 8'h01, 8'h02, 8'h00},  // R6 band1 -12
    {8'h0D, 8'h40, 8'h01, 8'h01, 8'h0B}   // R8 status untouched
  };

  function automatic logic [19:0] pk(int d1, int d2, int d3, int d4);
    return {5'(12 + d4), 5'(12 + d3), 5'(12 + d2), 5'(12 + d1)};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      if (gmode == 1 && i == 4) begin g_scl = 1'b1; tick(1); g_scl = 1'b0; end
      m_scl = 1'b1; tick(Q);
      if (gmode == 2 && b[i]) begin g_sda = 1'b1; tick(1); g_sda = 1'b0; end
      tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = ~sda_i; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); m_scl = 1'b1; tick(Q);
      b = {b[6:0], sda_i};
      tick(Q); m_scl = 1'b0;
    end
    tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic do_write(input logic [7:0] adr, input logic [7:0] c, input logic [7:0] d,
                          input bit hasd, output logic [2:0] acks);
    logic a;
    acks = 3'b111;
    i2c_start;
    send_byte(adr, a); acks[0] = a;
    send_byte(c, a);   acks[1] = a;
    if (hasd) begin send_byte(d, a); acks[2] = a; end
    i2c_stop;
    tick(16);
  endtask

  task automatic do_read(input logic [7:0] adr, output logic [7:0] b, output logic ack);
    i2c_start;
    send_byte(adr, ack);
    recv_byte(b);
    i2c_stop;
    tick(16);
  endtask

  initial begin
    logic [2:0] acks;
    logic [7:0] rb;
    logic ak;
    logic [39:0] fexp;
    tick(20);
    rst_n = 1'b1;
    tick(10);

    // R1 reset state
    chk("R1 dsp_off", dsp_off, 1);
    chk("R1 eq_mode", eq_mode, 0);
    chk("R1 level", level, 2'b01);
    chk("R1 band_gain", band_gain, pk(4, 0, 0, 1));
    chk("R1 filt_gain", filt_gain, {10{4'hC}});
    chk("R1 noise_thr", noise_thr, 8'h1F);
    chk("R1 sda_oe", sda_oe, 0);
    do_read(8'h81, rb, ak);
    chk("R2 read ack", ak, 1);
    chk("R1 R9 default status read", rb, 8'h05);
    chk("R12 released after read", sda_oe, 0);

    // table walk: command, query, read back
    for (int e = 0; e < 17; e++) begin
      do_write(8'h80, VEC[e][39:32], VEC[e][31:24], VEC[e][16], acks);
      chk($sformatf("R2 R10 acks entry %0d", e), acks, 3'b111);
      do_write(8'h80, 8'h0E, VEC[e][15:8], 1'b1, acks);
      do_read(8'h81, rb, ak);
      chk($sformatf("R9 readback entry %0d", e), rb, VEC[e][7:0]);
    end
    chk("R8 noise from table", noise_thr, 8'h40);

    // R4 presets seen at the ports
    do_write(8'h80, 8'h04, 8'h00, 1'b0, acks); chk("R4 flat", band_gain, pk(0, 0, 0, 0));
    do_write(8'h80, 8'h05, 8'h00, 1'b0, acks); chk("R4 preset1", band_gain, pk(3, -1, -1, 1));
    do_write(8'h80, 8'h06, 8'h00, 1'b0, acks); chk("R4 preset2", band_gain, pk(3, 0, 0, 3));
    do_write(8'h80, 8'h07, 8'h00, 1'b0, acks); chk("R4 preset3", band_gain, pk(5, 0, 0, 0));
    do_write(8'h80, 8'h08, 8'h00, 1'b0, acks); chk("R4 preset4", band_gain, pk(5, 0, 0, 1));

    // R3 mode at the ports
    do_write(8'h80, 8'h02, 8'h00, 1'b0, acks);
    chk("R3 vip", {dsp_off, eq_mode}, 2'b00);
    do_write(8'h80, 8'h03, 8'h00, 1'b0, acks);
    chk("R3 eq", {dsp_off, eq_mode}, 2'b01);
    do_write(8'h80, 8'h01, 8'h00, 1'b0, acks);
    chk("R3 bypass", {dsp_off, eq_mode}, 2'b11);

    // R7 filter gains
    fexp = {10{4'hC}};
    do_write(8'h80, 8'h0B, 8'h35, 1'b1, acks); fexp[12 +: 4] = 4'h5;
    chk("R7 filter3", filt_gain, fexp);
    do_write(8'h80, 8'h0B, 8'hA0, 1'b1, acks);
    chk("R7 index 10 ignored", filt_gain, fexp);
    do_write(8'h80, 8'h0B, 8'h3D, 1'b1, acks);
    chk("R7 gain 13 ignored", filt_gain, fexp);
    do_write(8'h80, 8'h0B, 8'h90, 1'b1, acks); fexp[36 +: 4] = 4'h0;
    chk("R7 filter9", filt_gain, fexp);

    // R8 noise threshold
    do_write(8'h80, 8'h0D, 8'h00, 1'b1, acks);
    chk("R8 noise zero", noise_thr, 8'h00);

    // R9 invalid query keeps selection (band1 of preset4 = 0x11)
    do_write(8'h80, 8'h0E, 8'h02, 1'b1, acks);
    do_write(8'h80, 8'h0E, 8'h06, 1'b1, acks);
    do_read(8'h81, rb, ak);
    chk("R9 query 06 ignored", rb, 8'h11);
    do_write(8'h80, 8'h0E, 8'h00, 1'b1, acks);
    do_read(8'h81, rb, ak);
    chk("R9 query 00 ignored", rb, 8'h11);

    // R2 address matching
    do_write(8'h82, 8'h02, 8'h00, 1'b0, acks);
    chk("R2 foreign address nack", acks[0], 0);
    chk("R2 foreign address no effect", dsp_off, 1);
    addr_sel = 1'b1;
    do_write(8'h82, 8'h02, 8'h00, 1'b0, acks);
    chk("R2 addr_sel=1 ack", acks, 3'b111);
    chk("R2 addr_sel=1 applied", dsp_off, 0);
    do_write(8'h80, 8'h01, 8'h00, 1'b0, acks);
    chk("R2 old address nack", acks[0], 0);
    chk("R2 old address no effect", dsp_off, 0);
    addr_sel = 1'b0;

    // R11 glitches
    gmode = 1;
    do_write(8'h80, 8'h09, 8'h00, 1'b1, acks);
    chk("R11 scl glitch acks", acks, 3'b111);
    chk("R11 scl glitch level", level, 2'b00);
    gmode = 2;
    do_write(8'h80, 8'h09, 8'h02, 1'b1, acks);
    chk("R11 sda glitch acks", acks, 3'b111);
    chk("R11 sda glitch level", level, 2'b10);
    gmode = 0;
    chk("R12 idle release", sda_oe, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule